// File: doc/BRIEF.md
# Loop Counter and Branch Unit

This block decides where a small coprocessor with 32-bit instructions fetches next. Each cycle it takes one decoded command, the word address of the current instruction, register R0, a register jump target, an immediate byte address, a signed byte step and a threshold. It returns the next word address and a taken flag in the same cycle. It also owns two pieces of state. The first is an 8-bit stage counter that programs use as a loop index. The second is a pair of result flags, zero and overflow, captured from the arithmetic unit.

Absolute jumps take their target from a register, already in words, or from a 13-bit byte immediate that is aligned to 4. They can be unconditional or can depend on a stored flag. Relative jumps add a byte step, divided by four, to the current word address. They are taken according to one of two comparisons: R0 against the threshold, or the stage counter against the threshold. Separate commands clear the stage counter, add an operand to it, or subtract an operand from it.

All branch decisions use the counter and flag values held before the current clock edge. Updates commanded in a cycle become visible in the following cycle.

Top module: `loop_branch_unit`

## Requirements
- R1: While `rst_n` is low, `stage_cnt`, `flag_zero` and `flag_ovf` read 0.
- R2: Command code 5 clears the stage counter at the next clock edge.
- R3: Command code 6 adds `stage_arg` to the stage counter and code 7 subtracts it; both wrap modulo 256.
- R4: Command codes 0 to 4 leave the stage counter unchanged, whatever the value of `stage_arg`.
- R5: When `alu_upd` is high, `flag_zero` and `flag_ovf` load `alu_zero` and `alu_ovf` at the clock edge. When it is low, both flags keep their values.
- R6: When no branch is taken, `taken` is 0 and `next_pc` is `pc_in`+1 modulo 2048. Command codes 0, 5, 6 and 7 are never taken.
- R7: Command code 1 targets the word address `reg_target`.
- R8: Command code 2 targets `imm_addr` divided by 4, which is bits 12:2 of the byte immediate.
- R9: For command codes 1 and 2, `cond` selects the condition: 0 is always taken, 1 is taken when the stored zero flag is set, 2 is taken when the stored overflow flag is set, and 3 is never taken.
- R10: Command code 3 compares R0 with `thresh` as unsigned numbers. `cond` 0 is taken when R0 >= thresh, 1 is taken when R0 < thresh, and 2 or 3 is never taken.
- R11: Command code 4 compares the stage counter, zero-extended to 16 bits, with `thresh`. `cond` 0 is taken when they are equal, 1 when the counter is less, 2 when it is greater, and 3 is never taken.
- R12: A taken command 3 or 4 targets `pc_in` plus the signed 10-bit `step` shifted arithmetically right by 2, modulo 2048.
- R13: `next_pc` and `taken` depend on the flag values held before the current edge. A flag update in the same cycle does not affect that cycle's decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 3 | Command code: 0 none, 1 register jump, 2 immediate jump, 3 R0 relative, 4 stage relative, 5 clear stage, 6 add stage, 7 subtract stage |
| cond | input | 2 | Condition select for the branch commands |
| pc_in | input | 11 | Word address of the current instruction |
| r0 | input | 16 | Value of register R0 |
| reg_target | input | 11 | Register jump target, in words |
| imm_addr | input | 13 | Immediate jump target, in bytes, aligned to 4 |
| step | input | 10 | Signed relative step, in bytes |
| thresh | input | 16 | Comparison threshold |
| stage_arg | input | 8 | Operand for adding to or subtracting from the stage counter |
| alu_upd | input | 1 | ALU result flags are valid this cycle |
| alu_zero | input | 1 | ALU result was zero |
| alu_ovf | input | 1 | ALU result overflowed |
| next_pc | output | 11 | Word address of the next instruction |
| taken | output | 1 | Branch taken this cycle |
| stage_cnt | output | 8 | Current stage counter |
| flag_zero | output | 1 | Stored zero flag |
| flag_ovf | output | 1 | Stored overflow flag |

## Verification
The bench uses the default parameters: an 11-bit word address, an 8-bit stage counter, 16-bit data and a 10-bit byte step. With these values, wrap of the address at 2047 in both directions can be reached with small steps. The stage counter wraps past 255 after two additions or one subtraction from a small value. The widest positive and negative steps also fit into a short table. Because the stage compare zero-extends the counter, thresholds above 255 show that the upper threshold bits take part in the comparison.

// File: rtl/lbu_pkg.sv
`timescale 1ns/1ps
package lbu_pkg;
  typedef enum logic [2:0] {
    BR_NONE = 3'd0,
    BR_JREG = 3'd1,
    BR_JIMM = 3'd2,
    BR_JR0  = 3'd3,
    BR_JSTG = 3'd4,
    ST_CLR  = 3'd5,
    ST_ADD  = 3'd6,
    ST_SUB  = 3'd7
  } br_op_e;

  localparam logic [1:0] C_ALWAYS = 2'd0;
  localparam logic [1:0] C_ZERO   = 2'd1;
  localparam logic [1:0] C_OVF    = 2'd2;
  localparam logic [1:0] C_GE     = 2'd0;
  localparam logic [1:0] C_LT     = 2'd1;
  localparam logic [1:0] C_EQ     = 2'd0;
  localparam logic [1:0] C_SLT    = 2'd1;
  localparam logic [1:0] C_SGT    = 2'd2;
endpackage

// File: rtl/lbu_stage_ctr.sv
`timescale 1ns/1ps
module lbu_stage_ctr #(
  parameter int STAGE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         op,
  input  logic [STAGE_W-1:0] arg,
  output logic [STAGE_W-1:0] cnt
);
  import lbu_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      case (br_op_e'(op))
        ST_CLR:  cnt <= '0;
        ST_ADD:  cnt <= cnt + arg;
        ST_SUB:  cnt <= cnt - arg;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/lbu_flags.sv
`timescale 1ns/1ps
module lbu_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic zero_in,
  input  logic ovf_in,
  output logic zero_q,
  output logic ovf_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (upd) begin
      zero_q <= zero_in;
      ovf_q  <= ovf_in;
    end
  end
endmodule

// File: rtl/lbu_cond_eval.sv
`timescale 1ns/1ps
module lbu_cond_eval #(
  parameter int DATA_W  = 16,
  parameter int STAGE_W = 8
) (
  input  logic [2:0]         op,
  input  logic [1:0]         cond,
  input  logic               fz,
  input  logic               fo,
  input  logic [DATA_W-1:0]  r0,
  input  logic [DATA_W-1:0]  thr,
  input  logic [STAGE_W-1:0] stage,
  output logic               take
);
  import lbu_pkg::*;

  logic [DATA_W-1:0] stage_ext;
  assign stage_ext = DATA_W'(stage);

  always_comb begin
    take = 1'b0;
    case (br_op_e'(op))
      BR_JREG, BR_JIMM: begin
        case (cond)
          C_ALWAYS: take = 1'b1;
          C_ZERO:   take = fz;
          C_OVF:    take = fo;
          default:  take = 1'b0;
        endcase
      end
      BR_JR0: begin
        case (cond)
          C_GE:    take = (r0 >= thr);
          C_LT:    take = (r0 < thr);
          default: take = 1'b0;
        endcase
      end
      BR_JSTG: begin
        case (cond)
          C_EQ:    take = (stage_ext == thr);
          C_SLT:   take = (stage_ext < thr);
          C_SGT:   take = (stage_ext > thr);
          default: take = 1'b0;
        endcase
      end
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/lbu_target_gen.sv
`timescale 1ns/1ps
module lbu_target_gen #(
  parameter int PC_W    = 11,
  parameter int JADDR_W = 13,
  parameter int STEP_W  = 10
) (
  input  logic [2:0]         op,
  input  logic [PC_W-1:0]    pc,
  input  logic [PC_W-1:0]    reg_tgt,
  input  logic [JADDR_W-1:0] imm,
  input  logic [STEP_W-1:0]  step,
  output logic [PC_W-1:0]    tgt
);
  import lbu_pkg::*;

  logic signed [STEP_W-1:0] step_words;
  logic signed [PC_W-1:0]   step_ext;
  logic [PC_W-1:0]          imm_words;

  assign step_words = $signed(step) >>> 2;
  assign step_ext   = PC_W'(step_words);
  assign imm_words  = PC_W'(imm >> 2);

  always_comb begin
    case (br_op_e'(op))
      BR_JREG:         tgt = reg_tgt;
      BR_JIMM:         tgt = imm_words;
      BR_JR0, BR_JSTG: tgt = pc + step_ext;
      default:         tgt = pc;
    endcase
  end
endmodule

// File: rtl/loop_branch_unit.sv
`timescale 1ns/1ps
module loop_branch_unit #(
  parameter int PC_W    = 11,
  parameter int DATA_W  = 16,
  parameter int STAGE_W = 8,
  parameter int JADDR_W = 13,
  parameter int STEP_W  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         op,
  input  logic [1:0]         cond,
  input  logic [PC_W-1:0]    pc_in,
  input  logic [DATA_W-1:0]  r0,
  input  logic [PC_W-1:0]    reg_target,
  input  logic [JADDR_W-1:0] imm_addr,
  input  logic [STEP_W-1:0]  step,
  input  logic [DATA_W-1:0]  thresh,
  input  logic [STAGE_W-1:0] stage_arg,
  input  logic               alu_upd,
  input  logic               alu_zero,
  input  logic               alu_ovf,
  output logic [PC_W-1:0]    next_pc,
  output logic               taken,
  output logic [STAGE_W-1:0] stage_cnt,
  output logic               flag_zero,
  output logic               flag_ovf
);
  logic [PC_W-1:0] tgt;
  logic [PC_W-1:0] pc_seq;
  logic            take;

  lbu_stage_ctr #(.STAGE_W(STAGE_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .op(op), .arg(stage_arg), .cnt(stage_cnt)
  );

  lbu_flags u_flags (
    .clk(clk), .rst_n(rst_n), .upd(alu_upd), .zero_in(alu_zero),
    .ovf_in(alu_ovf), .zero_q(flag_zero), .ovf_q(flag_ovf)
  );

  lbu_cond_eval #(.DATA_W(DATA_W), .STAGE_W(STAGE_W)) u_cond (
    .op(op), .cond(cond), .fz(flag_zero), .fo(flag_ovf), .r0(r0),
    .thr(thresh), .stage(stage_cnt), .take(take)
  );

  lbu_target_gen #(.PC_W(PC_W), .JADDR_W(JADDR_W), .STEP_W(STEP_W)) u_tgt (
    .op(op), .pc(pc_in), .reg_tgt(reg_target), .imm(imm_addr),
    .step(step), .tgt(tgt)
  );

  assign pc_seq  = pc_in + 1'b1;
  assign taken   = take;
  assign next_pc = take ? tgt : pc_seq;
endmodule

// File: rtl/lbu_checker.sv
`timescale 1ns/1ps
module lbu_checker #(
  parameter int PC_W    = 11,
  parameter int STAGE_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         op,
  input logic [STAGE_W-1:0] stage_arg,
  input logic               alu_upd,
  input logic               alu_zero,
  input logic               alu_ovf,
  input logic [PC_W-1:0]    pc_in,
  input logic [PC_W-1:0]    next_pc,
  input logic               taken,
  input logic [STAGE_W-1:0] stage_cnt,
  input logic               flag_zero,
  input logic               flag_ovf
);
  AST_STAGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd5) |=> (stage_cnt == '0)); // R2
  AST_STAGE_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd6) |=> (stage_cnt == STAGE_W'($past(stage_cnt) + $past(stage_arg)))); // R3
  AST_STAGE_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd7) |=> (stage_cnt == STAGE_W'($past(stage_cnt) - $past(stage_arg)))); // R3
  AST_STAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op < 3'd5) |=> $stable(stage_cnt)); // R4
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_upd |=> ($stable(flag_zero) && $stable(flag_ovf))); // R5
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    alu_upd |=> (flag_zero == $past(alu_zero) && flag_ovf == $past(alu_ovf))); // R5
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> (next_pc == PC_W'(pc_in + 1'b1))); // R6
  AST_NO_BRANCH_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd0 || op >= 3'd5) |-> !taken); // R6
endmodule

bind loop_branch_unit lbu_checker #(.PC_W(PC_W), .STAGE_W(STAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .stage_arg(stage_arg),
  .alu_upd(alu_upd), .alu_zero(alu_zero), .alu_ovf(alu_ovf),
  .pc_in(pc_in), .next_pc(next_pc), .taken(taken),
  .stage_cnt(stage_cnt), .flag_zero(flag_zero), .flag_ovf(flag_ovf)
);

// File: tb/sim_loop_branch_unit.sv
`timescale 1ns/1ps
module sim_loop_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  cond = '0;
  logic [10:0] pc_in = '0;
  logic [15:0] r0 = '0;
  logic [10:0] reg_target = '0;
  logic [12:0] imm_addr = '0;
  logic [9:0]  step = '0;
  logic [15:0] thresh = '0;
  logic [7:0]  stage_arg = '0;
  logic        alu_upd = 1'b0;
  logic        alu_zero = 1'b0;
  logic        alu_ovf = 1'b0;
  logic [10:0] next_pc;
  logic        taken;
  logic [7:0]  stage_cnt;
  logic        flag_zero;
  logic        flag_ovf;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  loop_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .op(op), .cond(cond), .pc_in(pc_in), .r0(r0),
    .reg_target(reg_target), .imm_addr(imm_addr), .step(step),
    .thresh(thresh), .stage_arg(stage_arg), .alu_upd(alu_upd),
    .alu_zero(alu_zero), .alu_ovf(alu_ovf), .next_pc(next_pc),
    .taken(taken), .stage_cnt(stage_cnt), .flag_zero(flag_zero),
    .flag_ovf(flag_ovf)
  );

  // op cond pc r0 reg_target imm step thresh taken expected_pc (stage 0, flags 0)
  localparam logic [93:0] VEC [0:18] = '{
    {3'd0, 2'd0, 11'd5,    16'd0,  11'd0,    13'd0,     10'd0,     16'd0,     1'b0, 11'd6},    // R6
    {3'd0, 2'd0, 11'd2047, 16'd0,  11'd0,    13'd0,     10'd0,     16'd0,     1'b0, 11'd0},    // R6 wrap
    {3'd1, 2'd0, 11'd10,   16'd0,  11'h123,  13'd0,     10'd0,     16'd0,     1'b1, 11'h123},  // R7
    {3'd1, 2'd1, 11'd10,   16'd0,  11'h123,  13'd0,     10'd0,     16'd0,     1'b0, 11'd11},   // R9
    {3'd2, 2'd0, 11'd7,    16'd0,  11'd0,    13'h120,   10'd0,     16'd0,     1'b1, 11'h48},   // R8
    {3'd2, 2'd3, 11'd7,    16'd0,  11'd0,    13'h120,   10'd0,     16'd0,     1'b0, 11'd8},    // R9
    {3'd2, 2'd2, 11'd7,    16'd0,  11'd0,    13'h120,   10'd0,     16'd0,     1'b0, 11'd8},    // R9
    {3'd3, 2'd0, 11'd100,  16'd20, 11'd0,    13'd0,     10'd16,    16'd20,    1'b1, 11'd104},  // R10
    {3'd3, 2'd0, 11'd100,  16'd19, 11'd0,    13'd0,     10'd16,    16'd20,    1'b0, 11'd101},  // R10
    {3'd3, 2'd1, 11'd100,  16'd19, 11'd0,    13'd0,     10'h3F8,   16'd20,    1'b1, 11'd98},   // R10 R12
    {3'd3, 2'd1, 11'd100,  16'd20, 11'd0,    13'd0,     10'h3F8,   16'd20,    1'b0, 11'd101},  // R10
    {3'd4, 2'd0, 11'd50,   16'd0,  11'd0,    13'd0,     10'd12,    16'd0,     1'b1, 11'd53},   // R11
    {3'd4, 2'd1, 11'd50,   16'd0,  11'd0,    13'd0,     10'h3FC,   16'd1,     1'b1, 11'd49},   // R11
    {3'd4, 2'd2, 11'd50,   16'd0,  11'd0,    13'd0,     10'd12,    16'd0,     1'b0, 11'd51},   // R11
    {3'd3, 2'd0, 11'd1,    16'd0,  11'd0,    13'd0,     10'h3F8,   16'd0,     1'b1, 11'd2047}, // R12 wrap
    {3'd1, 2'd0, 11'd2047, 16'd0,  11'd2047, 13'd0,     10'd0,     16'd0,     1'b1, 11'd2047}, // R7
    {3'd3, 2'd2, 11'd100,  16'd5,  11'd0,    13'd0,     10'd16,    16'd0,     1'b0, 11'd101},  // R10 never
    {3'd4, 2'd3, 11'd50,   16'd0,  11'd0,    13'd0,     10'd12,    16'd0,     1'b0, 11'd51},   // R11 never
    {3'd3, 2'd0, 11'd0,    16'd9,  11'd0,    13'd0,     10'h1FC,   16'd9,     1'b1, 11'd127}   // R12 max step
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    op = 3'd0; cond = 2'd0; pc_in = '0; r0 = '0; reg_target = '0;
    imm_addr = '0; step = '0; thresh = '0; stage_arg = '0;
    alu_upd = 1'b0; alu_zero = 1'b0; alu_ovf = 1'b0;
  endtask

  task automatic stage_cmd(input logic [2:0] o, input logic [7:0] a);
    @(negedge clk);
    idle();
    op = o; stage_arg = a;
    @(negedge clk);
    idle();
    #5;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 stage at reset", 32'(stage_cnt), 0);
    check("R1 zero flag at reset", 32'(flag_zero), 0);
    check("R1 ovf flag at reset", 32'(flag_ovf), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 19; i++) begin
      @(negedge clk);
      op = VEC[i][93:91]; cond = VEC[i][90:89]; pc_in = VEC[i][88:78];
      r0 = VEC[i][77:62]; reg_target = VEC[i][61:51]; imm_addr = VEC[i][50:38];
      step = VEC[i][37:28]; thresh = VEC[i][27:12];
      #5;
      check($sformatf("R6-R12 vector %0d taken", i), 32'(taken), 32'(VEC[i][11]));
      check($sformatf("R6-R12 vector %0d next_pc", i), 32'(next_pc), 32'(VEC[i][10:0]));
    end

    // stage counter arithmetic
    stage_cmd(3'd6, 8'd10);
    check("R3 add 10", 32'(stage_cnt), 10);
    stage_cmd(3'd6, 8'd250);
    check("R3 add wraps", 32'(stage_cnt), 4);
    stage_cmd(3'd7, 8'd5);
    check("R3 subtract wraps", 32'(stage_cnt), 255);

    // stage relative with counter at 255
    @(negedge clk);
    idle(); op = 3'd4; cond = 2'd2; thresh = 16'h10; pc_in = 11'd20; step = 10'd8; stage_arg = 8'd9;
    #5;
    check("R11 GT taken", 32'(taken), 1);
    check("R12 GT target", 32'(next_pc), 22);
    cond = 2'd1; thresh = 16'h100;
    #1;
    check("R11 LT wide threshold", 32'(taken), 1);
    cond = 2'd0; thresh = 16'h1FF;
    #1;
    check("R11 EQ upper bits differ", 32'(taken), 0);
    @(negedge clk);
    idle(); op = 3'd3; stage_arg = 8'd7;
    @(negedge clk);
    idle();
    #5;
    check("R4 stage kept across branches", 32'(stage_cnt), 255);
    stage_cmd(3'd5, 8'd0);
    check("R2 clear", 32'(stage_cnt), 0);

    // flags
    @(negedge clk);
    idle(); alu_upd = 1'b1; alu_zero = 1'b1; op = 3'd1; cond = 2'd1; reg_target = 11'h40; pc_in = 11'd3;
    #5;
    check("R13 same-cycle flag not used", 32'(taken), 0);
    check("R13 next_pc sequential", 32'(next_pc), 4);
    @(negedge clk);
    idle(); alu_zero = 1'b0; op = 3'd1; cond = 2'd1; reg_target = 11'h40; pc_in = 11'd3;
    #5;
    check("R5 zero flag loaded", 32'(flag_zero), 1);
    check("R9 EQ jump taken", 32'(next_pc), 11'h40);
    cond = 2'd2;
    #1;
    check("R9 OV jump not taken", 32'(taken), 0);
    @(negedge clk);
    #5;
    check("R5 zero flag held", 32'(flag_zero), 1);
    @(negedge clk);
    idle(); alu_upd = 1'b1; alu_ovf = 1'b1;
    @(negedge clk);
    idle(); op = 3'd2; cond = 2'd2; imm_addr = 13'h10; pc_in = 11'd9;
    #5;
    check("R5 ovf flag loaded", 32'(flag_ovf), 1);
    check("R9 OV jump target", 32'(next_pc), 4);
    cond = 2'd1;
    #1;
    check("R9 EQ after clear not taken", 32'(taken), 0);

    // reset mid-run
    stage_cmd(3'd6, 8'd3);
    rst_n = 1'b0;
    #2;
    check("R1 stage cleared by reset", 32'(stage_cnt), 0);
    check("R1 ovf cleared by reset", 32'(flag_ovf), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule